// File: doc/BRIEF.md
# Folded Systolic FIR Filter

This block is a finite impulse response filter built as a one-dimensional chain of identical processing cells. A sample enters at the head of the chain. A start token then moves through the chain one cell at a time. Each cell keeps a short private window of past samples. When the token reaches a cell, the cell multiplies its window by its own coefficients, adds the products to the partial sum handed over by the cell before it, and passes the new sum to the cell after it. The last cell delivers the finished sum at full precision. Samples, tokens and partial sums all travel toward the output end and never travel back.

The parameter `FOLD` sets how many taps each cell serves. With `FOLD = 1` the filter has one cell per tap and takes a new sample on every clock. With a larger `FOLD`, each cell owns a contiguous run of `FOLD` taps and works through them one per clock. The cell count is then `TAPS / FOLD` and the input rate falls to one sample every `FOLD` clocks. `TAPS` must be a multiple of `FOLD`.

Input handshake: a sample moves on a rising edge where `in_valid` and `in_ready` are both high. While `in_ready` is low the source holds its sample. The output side has no back-pressure: `out_valid` is a one-clock pulse at a fixed latency, and the consumer must take the value in that clock. Coefficients are loaded through a plain write port. A write takes effect only while the filter is empty.

Top module: `sfir_fold`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1. Every stored sample is zero.
- R2: For the n-th accepted sample, `out_data` equals the sum over j of c[j]·x[n−j]. The result is signed, exact, and `DW+CW+ceil(log2 TAPS)` bits wide. Any sample position before the first sample accepted after reset counts as zero.
- R3: `out_valid` is high for exactly one clock. It rises after the rising edge that comes `TAPS+1` edges after the edge that accepted the matching sample. There is one pulse per accepted sample, in acceptance order. With `FOLD > 1`, two pulses are never adjacent.
- R4: After each accepted sample, `in_ready` stays low for `FOLD−1` clocks and then returns high. With `FOLD = 1` it never drops. A sample offered while `in_ready` is low is not taken.
- R5: Idle clocks between samples (`in_valid` low) do not change any result. Outputs depend only on the sequence of accepted samples.
- R6: A coefficient write with `coef_addr = j` sets c[j]. c[j] is the weight applied to the sample accepted j samples before the current one, so j = 0 weights the newest sample.
- R7: A coefficient write is ignored in two cases. The first is any clock in which an accepted sample has not yet produced its output. The second is the clock in which a sample is accepted.
- R8: The extreme operands are exact and do not overflow. When every sample and coefficient is the most negative value, the result is `TAPS·2^(DW+CW−2)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered on `in_data` |
| in_ready | output | 1 | Filter can take a sample this clock |
| in_data | input | DW | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | ceil(log2 TAPS) | Tap index of the write |
| coef_data | input | CW | Signed coefficient value |
| out_valid | output | 1 | One-clock result pulse |
| out_data | output | DW+CW+ceil(log2 TAPS) | Signed full-precision result |

## Verification
The hardest case to reach from the ports is a coefficient write that lands while a sample is still moving through the chain. The filter looks quiet at its edges during this time, because `in_ready` is already back high and no result has appeared yet. The stimulus places a write on the clock right after a sample is accepted. It then drains the chain and sends an impulse, so that the coefficient that would have been corrupted shows up directly in the result. Two instances run side by side from the same sample sequence, one folded and one unfolded. Gapped and back-to-back streams are both used, so the per-cell windows and the token timing are checked under both an irregular arrival pattern and the highest input rate.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

  // Bits needed to hold an index into n entries (at least one).
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Full-precision accumulator width: product plus headroom for the taps.
  function automatic int acc_bits(input int dw, input int cw, input int taps);
    return dw + cw + idx_bits(taps);
  endfunction

endpackage

// File: rtl/sfir_issue.sv
module sfir_issue import sfir_pkg::*; #(
  parameter int F = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid_i,
  output logic in_ready_o,
  output logic accept_o
);
  localparam int GW = idx_bits(F);

  logic [GW-1:0] gap_q;

  assign in_ready_o = (gap_q == '0);
  assign accept_o   = in_valid_i && in_ready_o;

  // After an accepted sample, hold off for F-1 clocks so each cell
  // finishes its F sequential products before the next token arrives.
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (accept_o) begin
      gap_q <= GW'(F - 1);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  if (F > 1) begin : g_gap_chk
    p_ready_gap_r4: assert property (@(posedge clk) disable iff (rst)
      accept_o |=> !in_ready_o);
  end

endmodule

// File: rtl/sfir_cell.sv
module sfir_cell import sfir_pkg::*; #(
  parameter int DW   = 12,
  parameter int CW   = 12,
  parameter int AW   = 27,
  parameter int F    = 2,
  parameter int BASE = 0,
  parameter int ADW  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go_i,
  input  logic signed [DW-1:0] samp_i,
  input  logic signed [AW-1:0] sum_i,
  input  logic                 coef_we_i,
  input  logic [ADW-1:0]       coef_addr_i,
  input  logic signed [CW-1:0] coef_data_i,
  output logic                 go_o,
  output logic signed [DW-1:0] spill_o,
  output logic signed [AW-1:0] sum_o,
  output logic                 done_o,
  output logic                 active_o
);
  localparam int PW  = DW + CW;
  localparam int PHW = idx_bits(F);

  logic signed [DW-1:0] hist [F];
  logic signed [CW-1:0] coef [F];
  logic [F-1:0]         tok;
  logic                 run;
  logic [PHW-1:0]       ph;
  logic signed [PW-1:0] prod;
  logic                 pv, pfirst, plast;
  logic signed [AW-1:0] acc;
  logic                 done;
  logic signed [DW-1:0] spill;
  logic signed [DW-1:0] mul_x;
  logic signed [CW-1:0] mul_c;

  // Operand select: one fixed pair when unfolded, else the current phase.
  if (F == 1) begin : g_single
    assign mul_x = hist[0];
    assign mul_c = coef[0];
  end else begin : g_multi
    assign mul_x = hist[ph];
    assign mul_c = coef[ph];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < F; i++) begin
        hist[i] <= '0;
        coef[i] <= '0;
      end
      tok    <= '0;
      run    <= 1'b0;
      ph     <= '0;
      prod   <= '0;
      pv     <= 1'b0;
      pfirst <= 1'b0;
      plast  <= 1'b0;
      acc    <= '0;
      done   <= 1'b0;
      spill  <= '0;
    end else begin
      // Token delay line: the neighbour starts F clocks after this cell.
      tok[0] <= go_i;
      for (int i = 1; i < F; i++) tok[i] <= tok[i-1];

      // Local sample window; the dropped oldest sample feeds the neighbour.
      if (go_i) begin
        hist[0] <= samp_i;
        for (int i = 1; i < F; i++) hist[i] <= hist[i-1];
        spill <= hist[F-1];
      end

      // Multiplier stage, one tap per clock, registered before the adder.
      pv <= run;
      if (run) begin
        prod   <= mul_x * mul_c;
        pfirst <= (ph == '0);
        plast  <= (ph == PHW'(F - 1));
        ph     <= ph + 1'b1;
        if (ph == PHW'(F - 1)) run <= 1'b0;
      end
      if (go_i) begin
        run <= 1'b1;
        ph  <= '0;
      end

      // Adder stage: the first product of a group picks up the upstream sum.
      done <= pv && plast;
      if (pv) begin
        acc <= (pfirst ? sum_i : acc) + {{(AW-PW){prod[PW-1]}}, prod};
      end

      for (int j = 0; j < F; j++) begin
        if (coef_we_i && (32'(coef_addr_i) == 32'(BASE + j))) coef[j] <= coef_data_i;
      end
    end
  end

  assign go_o     = tok[F-1];
  assign spill_o  = spill;
  assign sum_o    = acc;
  assign done_o   = done;
  assign active_o = run || pv || (|tok);

  // A new token must never cut into an unfinished product group.
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    go_i |-> (!run || ph == PHW'(F - 1)));

  // Coefficients may only change while this cell is quiet.
  p_write_idle_r7: assert property (@(posedge clk) disable iff (rst)
    coef_we_i |-> !active_o);

endmodule

// File: rtl/sfir_fold.sv
module sfir_fold import sfir_pkg::*; #(
  parameter  int TAPS  = 8,
  parameter  int FOLD  = 2,
  parameter  int DW    = 12,
  parameter  int CW    = 12,
  localparam int AW    = acc_bits(DW, CW, TAPS),
  localparam int ADW   = idx_bits(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  input  logic                 coef_we,
  input  logic [ADW-1:0]       coef_addr,
  input  logic signed [CW-1:0] coef_data,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data
);
  localparam int CELLS = TAPS / FOLD;

  logic                 accept;
  logic                 busy;
  logic                 we_eff;
  logic [CELLS:0]       go;
  logic [CELLS-1:0]     done;
  logic [CELLS-1:0]     act;
  logic signed [DW-1:0] samp  [CELLS+1];
  logic signed [AW-1:0] sum_w [CELLS+1];
  logic                 unused_tail;

  sfir_issue #(.F(FOLD)) u_issue (
    .clk        (clk),
    .rst        (rst),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .accept_o   (accept)
  );

  assign go[0]    = accept;
  assign samp[0]  = in_data;
  assign sum_w[0] = '0;
  assign busy     = |act;
  assign we_eff   = coef_we && !busy && !accept;

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    sfir_cell #(
      .DW(DW), .CW(CW), .AW(AW), .F(FOLD), .BASE(k * FOLD), .ADW(ADW)
    ) u_cell (
      .clk         (clk),
      .rst         (rst),
      .go_i        (go[k]),
      .samp_i      (samp[k]),
      .sum_i       (sum_w[k]),
      .coef_we_i   (we_eff),
      .coef_addr_i (coef_addr),
      .coef_data_i (coef_data),
      .go_o        (go[k+1]),
      .spill_o     (samp[k+1]),
      .sum_o       (sum_w[k+1]),
      .done_o      (done[k]),
      .active_o    (act[k])
    );
  end

  assign out_valid   = done[CELLS-1];
  assign out_data    = sum_w[CELLS];
  assign unused_tail = ^{samp[CELLS], go[CELLS], done};

  // An accepted sample keeps the chain busy, which blocks writes.
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  if (FOLD > 1) begin : g_spacing
    p_out_spacing_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);
  end

endmodule

// File: tb/sfir_fold_tb.sv
module sfir_fold_tb;
  localparam int T0 = 8;
  localparam int T1 = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              v0 = 0, we0 = 0, r0, ov0;
  logic signed [7:0] d0 = 0, cd0 = 0;
  logic [2:0]        a0 = 0;
  logic signed [18:0] od0;
  logic              v1 = 0, we1 = 0, r1, ov1;
  logic signed [7:0] d1 = 0, cd1 = 0;
  logic [1:0]        a1 = 0;
  logic signed [17:0] od1;

  sfir_fold #(.TAPS(T0), .FOLD(2), .DW(8), .CW(8)) u_dut (
    .clk(clk), .rst(rst), .in_valid(v0), .in_ready(r0), .in_data(d0),
    .coef_we(we0), .coef_addr(a0), .coef_data(cd0),
    .out_valid(ov0), .out_data(od0));

  sfir_fold #(.TAPS(T1), .FOLD(1), .DW(8), .CW(8)) u_dut_f1 (
    .clk(clk), .rst(rst), .in_valid(v1), .in_ready(r1), .in_data(d1),
    .coef_we(we1), .coef_addr(a1), .coef_data(cd1),
    .out_valid(ov1), .out_data(od1));

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit mon_on = 0, done_all = 0, e0, e1;
  string cur_req = "R2";
  longint h0 [T0], c0 [T0], h1 [T1], c1 [T1];
  longint qd0[$], qv0[$], qd1[$], qv1[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Output monitors: timing against R3, value against the active requirement.
  always @(negedge clk) begin
    if (mon_on) begin
      e0 = (qd0.size() > 0) && (qd0[0] == longint'(cyc));
      if (e0 || ov0) begin
        check(ov0 == e0, "R3", ov0, e0);
        if (e0 && ov0) check(longint'(od0) == qv0[0], cur_req, od0, qv0[0]);
      end
      if (e0) begin void'(qd0.pop_front()); void'(qv0.pop_front()); end
      e1 = (qd1.size() > 0) && (qd1[0] == longint'(cyc));
      if (e1 || ov1) begin
        check(ov1 == e1, "R3", ov1, e1);
        if (e1 && ov1) check(longint'(od1) == qv1[0], cur_req, od1, qv1[0]);
      end
      if (e1) begin void'(qd1.pop_front()); void'(qv1.pop_front()); end
    end
  end

  task automatic model0(input longint x);
    longint y = 0;
    for (int j = T0 - 1; j > 0; j--) h0[j] = h0[j-1];
    h0[0] = x;
    for (int j = 0; j < T0; j++) y += c0[j] * h0[j];
    qd0.push_back(cyc + T0 + 2);
    qv0.push_back(y);
  endtask

  task automatic model1(input longint x);
    longint y = 0;
    for (int j = T1 - 1; j > 0; j--) h1[j] = h1[j-1];
    h1[0] = x;
    for (int j = 0; j < T1; j++) y += c1[j] * h1[j];
    qd1.push_back(cyc + T1 + 2);
    qv1.push_back(y);
  endtask

  // Tasks start and end half a clock from the rising edge (negedge + 1).
  task automatic push(input int x);
    bit g0 = 0, g1 = 0;
    v0 = 1; d0 = 8'(x); v1 = 1; d1 = 8'(x);
    while (!(g0 && g1)) begin
      bit n0 = 0, n1 = 0;
      if (!g0 && r0) begin model0(x); g0 = 1; n0 = 1; end
      if (!g1 && r1) begin model1(x); g1 = 1; n1 = 1; end
      @(negedge clk); #1;
      if (g0) v0 = 0;
      if (g1) v1 = 0;
      if (n0) check(r0 == 1'b0, "R4", r0, 0);
      if (n1) check(r1 == 1'b1, "R4", r1, 1);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic drain();
    while (qd0.size() != 0 || qd1.size() != 0) begin @(negedge clk); #1; end
  endtask

  // The model applies a write only when nothing is in flight (R7).
  task automatic wr0(input int j, input int c);
    we0 = 1; a0 = 3'(j); cd0 = 8'(c);
    if (qd0.size() == 0) c0[j] = c;
    @(negedge clk); #1;
    we0 = 0;
  endtask

  task automatic wr1(input int j, input int c);
    we1 = 1; a1 = 2'(j); cd1 = 8'(c);
    if (qd1.size() == 0) c1[j] = c;
    @(negedge clk); #1;
    we1 = 0;
  endtask

  task automatic t_reset();
    check(ov0 == 0 && ov1 == 0, "R1", {ov0, ov1}, 0);
    check(od0 == 0, "R1", od0, 0);
    check(od1 == 0, "R1", od1, 0);
    check(r0 == 1 && r1 == 1, "R1", {r0, r1}, 3);
  endtask

  task automatic t_impulse();
    cur_req = "R6";
    for (int j = 0; j < T0; j++) wr0(j, 3 * j - 10);
    for (int j = 0; j < T1; j++) wr1(j, 7 - 5 * j);
    push(1);
    for (int i = 0; i < T0; i++) push(0);
    drain();
  endtask

  task automatic t_stream();
    cur_req = "R2";
    for (int i = 0; i < 24; i++) push(((i * 37 + 11) % 256) - 128);
    drain();
  endtask

  task automatic t_gaps();
    cur_req = "R5";
    for (int i = 0; i < 16; i++) begin
      push(((i * 53 + 7) % 200) - 100);
      idle(i % 4);
    end
    drain();
  endtask

  task automatic t_busy_write();
    cur_req = "R7";
    push(1);
    wr0(0, 55);
    wr1(0, 55);
    push(2);
    wr0(T0 - 1, -55);
    drain();
    for (int i = 0; i < T0; i++) push(0);
    push(1);
    for (int i = 0; i < T0; i++) push(0);
    drain();
  endtask

  task automatic t_fullscale();
    cur_req = "R8";
    for (int j = 0; j < T0; j++) wr0(j, -128);
    for (int j = 0; j < T1; j++) wr1(j, -128);
    for (int i = 0; i < T0; i++) push(-128);
    for (int i = 0; i < T0; i++) push(127);
    drain();
  endtask

  initial begin
    for (int j = 0; j < T0; j++) begin h0[j] = 0; c0[j] = 0; end
    for (int j = 0; j < T1; j++) begin h1[j] = 0; c1[j] = 0; end
    repeat (4) @(negedge clk);
    #1 rst = 0;
    mon_on = 1;
    t_reset();
    t_impulse();
    t_stream();
    t_gaps();
    t_busy_write();
    t_fullscale();
    idle(4);
    done_all = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_all) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule